// File: doc/BRIEF.md
# Serial Sampling-Converter Port Emulator

This block acts as the digital face of a single-channel sampling converter. A system test can use it in place of the real device. A host master drives an active-low frame select (`cs_n`) and a serial clock (`sclk`). The block answers on a single data line with an output-enable beside it. When the frame opens, it captures a parallel sample word. It then shifts that word out on falling serial-clock edges, between two leading zeros and trailing zeros.

The block also models the converter's internal state. A track/hold flag shows whether the front end is holding. A power-down flag is set by a short frame at the narrowest resolution and cleared by the next complete frame. A stale flag marks the frame that wakes the block from power-down. Both host inputs are oversampled by the fast system clock `clk` and edge-detected.

The control is a four-state machine:
- IDLE: output off, tracking.
- HOLD: output on, holding.
- TRACK: output on, tracking again while the last bits still go out.
- DONE: output off, waiting for the frame to close.

Its transitions are:
- IDLE to HOLD on a frame-select fall.
- HOLD to TRACK on the serial rising edge that follows the hold-end fall.
- HOLD or TRACK to DONE on the sixteenth fall.
- HOLD, TRACK or DONE to IDLE on a frame-select rise.

Top module: `adc_serial_port_emu`

## Requirements
- R1: After reset the output-enable, hold flag, power-down flag and stale flag are all 0, and `sdo` is 0.
- R2: A frame-select fall from idle enables the output, raises the hold flag and drives a 0 on `sdo`.
- R3: Each serial-clock fall advances one output position. Position 1 is a zero. Positions 2 to N+1 carry the data MSB first. Later positions are zeros.
- R4: The hold flag drops on the serial rising edge that follows fall N+1, which is fall 13, 11 or 9 for 12, 10 or 8 bits. It stays high before that edge.
- R5: The output is disabled on the 16th serial-clock fall, and further falls leave it disabled. It is also disabled within four system clocks of a frame-select rise.
- R6: `res_sel` chooses the resolution N: 00 gives 12 bits, 01 gives 10 bits, 10 gives 8 bits and 11 gives 12 bits. The data are the top N bits of `sample_in`. The value is latched at the frame-select fall.
- R7: A frame-select rise after fewer than N+2 falls ends the frame, which leaves the output off and the hold flag low. At 12 or 10 bits this does not change the power-down flag.
- R8: At 8 bits, a frame-select rise after fewer than 10 falls sets the power-down flag.
- R9: A frame that reaches N+2 falls before frame-select rises clears the power-down flag. A frame that opens while powered down shows the stale flag until it ends.
- R10: `sample_in` is captured at the frame-select fall. Changes to it later in the frame do not alter the shifted bits.
- R11: A serial-clock fall that is seen in the same system clock as a frame-select rise is not counted toward the N+2 falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host, idles high |
| res_sel | input | 2 | Resolution select (see R6) |
| sample_in | input | DATA_W | Parallel sample word |
| sdo | output | 1 | Serial data bit, 0 when not enabled |
| sdo_oe | output | 1 | Output enable for the data line |
| hold | output | 1 | 1 while the front end holds |
| pwr_down | output | 1 | Power-down state |
| sample_stale | output | 1 | Current frame began in power-down |

## Verification
The frame-end decision and the fall counter can meet in one system clock. This happens when the host releases frame select together with the serial-clock fall that would complete the frame. The bench provokes it at 8 bits by driving both input changes on the same clock edge, at the tenth fall. The two signals then pass through identical synchronizers and arrive together. The bench judges the result at the ports: the output must be off, and the power-down flag must be set, because only nine falls counted.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_TRACK = 2'd2,
        ST_DONE  = 2'd3
    } emu_state_e;

    // Resolution code: 01 -> W-2, 10 -> W-4, others -> W
    function automatic int unsigned res_width(input logic [1:0] sel, input int unsigned full_w);
        unique case (sel)
            2'b01:   return full_w - 2;
            2'b10:   return full_w - 4;
            default: return full_w;
        endcase
    endfunction

endpackage

// File: rtl/adc_emu_edge.sv
module adc_emu_edge #(
    parameter int   SYNC_STAGES = 2,
    parameter logic IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [SYNC_STAGES:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {(SYNC_STAGES+1){IDLE_LEVEL}};
        else        sh_q <= {sh_q[SYNC_STAGES-1:0], din};
    end

    assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
    assign fall = ~sh_q[SYNC_STAGES-1] & sh_q[SYNC_STAGES];
endmodule

// File: rtl/adc_emu_bitsel.sv
module adc_emu_bitsel #(
    parameter int DATA_W = 12,
    parameter int LEAD   = 2,
    parameter int CW     = 5
) (
    input  logic [DATA_W-1:0] word,
    input  logic [CW-1:0]     pos,
    input  logic [CW-1:0]     nbits,
    output logic              bit_o
);
    int p_i;
    int n_i;

    always_comb begin
        p_i   = int'(pos);
        n_i   = int'(nbits);
        bit_o = 1'b0;
        if (p_i >= LEAD && p_i < LEAD + n_i)
            bit_o = word[DATA_W-1-(p_i-LEAD)];
    end
endmodule

// File: rtl/adc_emu_ctrl.sv
module adc_emu_ctrl
    import adc_emu_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int LEAD        = 2,
    parameter int FRAME_FALLS = 16,
    localparam int CW         = $clog2(FRAME_FALLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              sck_fall,
    input  logic              sck_rise,
    input  logic [1:0]        res_sel,
    input  logic [DATA_W-1:0] sample_in,
    output logic [CW-1:0]     cnt,
    output logic [CW-1:0]     nbits,
    output logic [DATA_W-1:0] word,
    output logic              oe,
    output logic              hold,
    output logic              pd,
    output logic              stale
);
    localparam logic [CW-1:0] LAST_FALL = CW'(FRAME_FALLS - 1);
    localparam logic [CW-1:0] NARROW_W  = CW'(DATA_W - 4);

    emu_state_e      state, state_n;
    logic [CW-1:0]   need_falls, hold_end;

    assign need_falls = nbits + CW'(LEAD);
    assign hold_end   = nbits + CW'(LEAD - 1);

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  if (cs_fall) state_n = ST_HOLD;
            ST_HOLD: begin
                if (cs_rise)                                 state_n = ST_IDLE;
                else if (sck_rise && cnt == hold_end)        state_n = ST_TRACK;
                else if (sck_fall && cnt == LAST_FALL)       state_n = ST_DONE;
            end
            ST_TRACK: begin
                if (cs_rise)                                 state_n = ST_IDLE;
                else if (sck_fall && cnt == LAST_FALL)       state_n = ST_DONE;
            end
            ST_DONE:  if (cs_rise) state_n = ST_IDLE;
        endcase
    end

    // state register and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            nbits <= CW'(DATA_W);
            word  <= '0;
            pd    <= 1'b0;
            stale <= 1'b0;
        end else begin
            state <= state_n;
            if (state == ST_IDLE) begin
                if (cs_fall) begin
                    cnt   <= '0;
                    word  <= sample_in;
                    nbits <= CW'(res_width(res_sel, DATA_W));
                    stale <= pd;
                end
            end else if (cs_rise) begin
                stale <= 1'b0;
                cnt   <= '0;
                if (cnt < need_falls) begin
                    if (nbits == NARROW_W) pd <= 1'b1;
                end else begin
                    pd <= 1'b0;
                end
            end else if (sck_fall && state != ST_DONE) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        oe   = (state == ST_HOLD) || (state == ST_TRACK);
        hold = (state == ST_HOLD);
    end

    p_open_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && state == ST_IDLE) |=> (hold && oe && cnt == '0));
    p_fall_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(FRAME_FALLS));
    p_done_after_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |-> (cnt == CW'(FRAME_FALLS)));
    p_track_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK) |-> (cnt >= hold_end));
    p_pd_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd) |-> ($past(nbits) == NARROW_W && $past(cs_rise)));
    p_pd_wake_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd) |-> ($past(cnt) >= $past(need_falls)));
endmodule

// File: rtl/adc_serial_port_emu.sv
module adc_serial_port_emu #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [1:0]        res_sel,
    input  logic [DATA_W-1:0] sample_in,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              hold,
    output logic              pwr_down,
    output logic              sample_stale
);
    localparam int LEAD        = 2;
    localparam int FRAME_FALLS = 16;
    localparam int CW          = $clog2(FRAME_FALLS + 1);

    logic          cs_rise, cs_fall, sck_rise, sck_fall;
    logic [CW-1:0] cnt, nbits;
    logic [DATA_W-1:0] word;
    logic          bit_v, oe;

    adc_emu_edge #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .rise(cs_rise), .fall(cs_fall));

    adc_emu_edge #(.SYNC_STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sck_edge (
        .clk(clk), .rst_n(rst_n), .din(sclk), .rise(sck_rise), .fall(sck_fall));

    adc_emu_ctrl #(.DATA_W(DATA_W), .LEAD(LEAD), .FRAME_FALLS(FRAME_FALLS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sck_fall(sck_fall), .sck_rise(sck_rise),
        .res_sel(res_sel), .sample_in(sample_in),
        .cnt(cnt), .nbits(nbits), .word(word),
        .oe(oe), .hold(hold), .pd(pwr_down), .stale(sample_stale));

    adc_emu_bitsel #(.DATA_W(DATA_W), .LEAD(LEAD), .CW(CW)) u_bitsel (
        .word(word), .pos(cnt), .nbits(nbits), .bit_o(bit_v));

    assign sdo_oe = oe;
    assign sdo    = oe & bit_v;

    p_quiet_when_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);
    p_hold_inside_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $rose(sdo_oe));
endmodule

// File: tb/adc_serial_port_emu_tb.sv
module adc_serial_port_emu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [1:0]  res_sel = 2'b00;
    logic [11:0] sample_in = '0;
    logic        sdo, sdo_oe, hold, pwr_down, sample_stale;

    int checks = 0;
    int failures = 0;
    bit pd_model = 1'b0;

    always #5 clk = ~clk;

    adc_serial_port_emu u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .res_sel(res_sel), .sample_in(sample_in),
        .sdo(sdo), .sdo_oe(sdo_oe), .hold(hold),
        .pwr_down(pwr_down), .sample_stale(sample_stale));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    function automatic int width_of(input logic [1:0] rs);
        return (rs == 2'b01) ? 10 : (rs == 2'b10) ? 8 : 12;
    endfunction

    task automatic t_reset();
        check("R1 oe", 32'(sdo_oe), 0);
        check("R1 hold", 32'(hold), 0);
        check("R1 pwr_down", 32'(pwr_down), 0);
        check("R1 stale", 32'(sample_stale), 0);
        check("R1 sdo", 32'(sdo), 0);
    endtask

    // one frame: nfalls serial falls; coinc makes the last fall coincide with frame-select rise
    task automatic run_frame(input logic [1:0] rs, input logic [11:0] w, input int nfalls,
                             input bit mid_change, input bit coinc, input string end_tag);
        int n;
        int counted;
        bit exp_stale;
        n = width_of(rs);
        exp_stale = pd_model;
        sample_in = w;
        res_sel = rs;
        cs_n = 1'b0;
        settle();
        check("R2 oe at open", 32'(sdo_oe), 1);
        check("R2 hold at open", 32'(hold), 1);
        check("R2 first zero", 32'(sdo), 0);
        check("R9 stale flag", 32'(sample_stale), 32'(exp_stale));
        if (mid_change) begin
            sample_in = ~w;
            res_sel = rs ^ 2'b01;
        end
        for (int k = 1; k <= nfalls; k++) begin
            if (coinc && k == nfalls) break;
            sclk = 1'b0;
            settle();
            check(mid_change ? "R10 bit" : "R3 R6 bit", 32'(sdo),
                  (k >= 2 && k < n + 2) ? 32'(w[13-k]) : 0);
            check("R5 oe per fall", 32'(sdo_oe), (k < 16) ? 1 : 0);
            sclk = 1'b1;
            settle();
            check("R4 hold point", 32'(hold), (k < n + 1) ? 1 : 0);
        end
        if (coinc) begin
            cs_n = 1'b1;
            sclk = 1'b0;
            settle();
            sclk = 1'b1;
            settle();
            counted = nfalls - 1;
        end else begin
            cs_n = 1'b1;
            repeat (4) @(negedge clk);
            check("R5 off after cs rise", 32'(sdo_oe), 0);
            settle();
            counted = nfalls;
        end
        if (counted >= n + 2) pd_model = 1'b0;
        else if (n == 8)      pd_model = 1'b1;
        check("R7 oe after end", 32'(sdo_oe), 0);
        check("R7 hold after end", 32'(hold), 0);
        check(end_tag, 32'(pwr_down), 32'(pd_model));
        check("R9 stale cleared", 32'(sample_stale), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        settle();
        t_reset();
        run_frame(2'b00, 12'hA5C, 16, 1'b0, 1'b0, "R9 full 12-bit pd");
        run_frame(2'b01, 12'h3F1, 16, 1'b0, 1'b0, "R6 full 10-bit pd");
        run_frame(2'b10, 12'hC3A, 14, 1'b0, 1'b0, "R5 8-bit 14 falls pd");
        run_frame(2'b00, 12'h777, 8, 1'b0, 1'b0, "R7 12-bit abort pd");
        run_frame(2'b01, 12'h5B3, 6, 1'b0, 1'b0, "R7 10-bit abort pd");
        run_frame(2'b11, 12'h9B4, 18, 1'b1, 1'b0, "R10 latched frame pd");
        run_frame(2'b10, 12'h5A5, 5, 1'b0, 1'b0, "R8 8-bit short pd");
        run_frame(2'b00, 12'h123, 6, 1'b0, 1'b0, "R7 abort while down pd");
        run_frame(2'b00, 12'hFED, 14, 1'b0, 1'b0, "R9 wake frame pd");
        run_frame(2'b10, 12'h0F0, 10, 1'b0, 1'b1, "R11 coincident edge pd");
        run_frame(2'b10, 12'hAAA, 10, 1'b0, 1'b0, "R9 8-bit wake pd");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule